// File: doc/BRIEF.md
# UART Interrupt Cause Identifier

This block turns the state around a UART's two FIFOs into interrupt causes and reports the most urgent pending cause as a 4-bit identifier code. It watches the transmit and receive occupancy counts, the receive push and pop strobes, the transmit write strobe, a one-cycle tick per character time, receive error pulses and modem-line change pulses. The FIFOs, the serializer and the register bus sit outside it. The bus reads `irq_id` and the interrupt line follows `irq_pending`.

Trigger levels have two forms. The coarse form takes a 2-bit selector. The points it picks depend on the FIFO depth parameter, which is 16 or 32. The fine form takes a 5-bit level. The receive side also has a timeout. It raises a cause when data waits in the FIFO and no push or pop has happened for a set number of character times.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held and after it is released with no cause present, `irq_id` is 0x1 (bit 0 set means nothing pending) and `irq_pending` is 0.
- R2: Coarse transmit trigger (`fine_mode`=0, `tx_level[1:0]`): selector 0 fires when count < DEPTH; 1 when count < 3*DEPTH/4; 2 when count < DEPTH/2; 3 when count < DEPTH/4.
- R3: Coarse receive trigger (`rx_level[1:0]`): selector 0 fires when count > 0; 1 when count > DEPTH/4-1; 2 when count > DEPTH/2-1; 3 when count > 7*DEPTH/8-1 (13 at depth 16, 27 at depth 32).
- R4: With `fine_mode`=1, the transmit trigger fires when count <= `tx_level` and the receive trigger fires when count > `rx_level`.
- R5: The receive timeout cause is present when the receive count is nonzero and TIMEOUT_CHARS `char_tick` pulses (default 4) have come with no `rx_push` or `rx_pop` in between. A push, a pop or an empty FIFO restarts the count.
- R6: The transmit cause latches when the transmit trigger goes from false to true. A `tx_write` pulse clears it, and it stays clear until the trigger rises again.
- R7: The line-status cause is set by an `ls_error` pulse and held until an `ls_read` pulse. A new error in the same cycle as the read keeps it set.
- R8: The modem cause is set by `modem_change` and cleared by `modem_read`. While `auto_flow` is 1 it is neither set nor reported.
- R9: Codes and priority, highest first: line status 0x6, receive timeout 0xC, receive data 0x4, transmit slot 0x2, modem 0x0.
- R10: `irq_id` and `irq_pending` are registered. A change at the inputs shows up at them two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fine_mode | input | 1 | 1 selects 5-bit trigger levels, 0 selects 2-bit selectors |
| tx_level | input | 5 | Transmit trigger level or selector |
| rx_level | input | 5 | Receive trigger level or selector |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_write | input | 1 | Transmit FIFO write strobe |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_pop | input | 1 | Receive FIFO pop strobe |
| char_tick | input | 1 | One pulse per character time |
| ls_error | input | 1 | Receive line error pulse |
| ls_read | input | 1 | Line status read strobe |
| modem_change | input | 1 | Modem line change pulse |
| modem_read | input | 1 | Modem status read strobe |
| auto_flow | input | 1 | Automatic flow control enabled |
| irq_id | output | 4 | Highest-priority pending cause code |
| irq_pending | output | 1 | Any cause pending |

## Verification
The assertions assume that strobes are single-cycle pulses, that both occupancy counts stay within 0..DEPTH, and that reset is held for at least one clock edge before checking starts. The stimulus changes inputs only on falling edges. It drives every strobe high for exactly one cycle, keeps the counts in range, and holds reset for several cycles. The counts are driven directly rather than produced by a real FIFO, so the bench can move occupancy to any threshold boundary without generating traffic.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [3:0] ID_MODEM   = 4'h0;
  localparam logic [3:0] ID_NONE    = 4'h1;
  localparam logic [3:0] ID_TX_SLOT = 4'h2;
  localparam logic [3:0] ID_RX_DATA = 4'h4;
  localparam logic [3:0] ID_LINE    = 4'h6;
  localparam logic [3:0] ID_RX_TMO  = 4'hC;

  typedef struct packed {
    logic line;
    logic tmo;
    logic rxd;
    logic txs;
    logic mdm;
  } cause_t;

  function automatic logic id_legal(input logic [3:0] id);
    return id == ID_MODEM || id == ID_NONE || id == ID_TX_SLOT ||
           id == ID_RX_DATA || id == ID_LINE || id == ID_RX_TMO;
  endfunction
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int DEPTH   = 16,
  parameter bit FINE_EN = 1'b1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             fine_mode,
  input  logic [4:0]       tx_level,
  input  logic [4:0]       rx_level,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  output logic             tx_trig,
  output logic             rx_trig
);
  localparam int TX_Q3 = (3 * DEPTH) / 4;
  localparam int TX_H  = DEPTH / 2;
  localparam int TX_Q1 = DEPTH / 4;
  localparam int RX_Q1 = DEPTH / 4 - 1;
  localparam int RX_H  = DEPTH / 2 - 1;
  localparam int RX_HI = (7 * DEPTH) / 8 - 1;

  logic tx_coarse, rx_coarse;
  int   txc, rxc;

  assign txc = 32'(tx_count);
  assign rxc = 32'(rx_count);

  always_comb begin
    case (tx_level[1:0])
      2'd0:    tx_coarse = txc < DEPTH;
      2'd1:    tx_coarse = txc < TX_Q3;
      2'd2:    tx_coarse = txc < TX_H;
      default: tx_coarse = txc < TX_Q1;
    endcase
    case (rx_level[1:0])
      2'd0:    rx_coarse = rxc > 0;
      2'd1:    rx_coarse = rxc > RX_Q1;
      2'd2:    rx_coarse = rxc > RX_H;
      default: rx_coarse = rxc > RX_HI;
    endcase
  end

  generate
    if (FINE_EN) begin : g_fine
      logic tx_fine, rx_fine;
      assign tx_fine = txc <= 32'(tx_level);
      assign rx_fine = rxc >  32'(rx_level);
      assign tx_trig = fine_mode ? tx_fine : tx_coarse;
      assign rx_trig = fine_mode ? rx_fine : rx_coarse;
    end else begin : g_coarse
      assign tx_trig = tx_coarse;
      assign rx_trig = rx_coarse;
    end
  endgenerate
endmodule

// File: rtl/uart_irq_rxto.sv
module uart_irq_rxto #(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TW    = $clog2(TIMEOUT_CHARS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  output logic             timeout
);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CHARS);
  logic [TW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst || rx_push || rx_pop || rx_count == '0) quiet <= '0;
    else if (char_tick && quiet != LIMIT)            quiet <= quiet + 1'b1;
  end

  assign timeout = (quiet == LIMIT) && (rx_count != '0);

  a_r5_quiet_bounded: assert property (@(posedge clk) disable iff (rst)
    quiet <= LIMIT);
  a_r5_no_tmo_when_empty: assert property (@(posedge clk) disable iff (rst)
    rx_count == '0 |-> !timeout);
  a_r5_activity_restarts: assert property (@(posedge clk) disable iff (rst)
    (rx_push || rx_pop) |=> quiet == '0);
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
(
  input  cause_t     cause,
  output logic [3:0] id
);
  always_comb begin
    if      (cause.line) id = ID_LINE;
    else if (cause.tmo)  id = ID_RX_TMO;
    else if (cause.rxd)  id = ID_RX_DATA;
    else if (cause.txs)  id = ID_TX_SLOT;
    else if (cause.mdm)  id = ID_MODEM;
    else                 id = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4,
  parameter bit FINE_EN       = 1'b1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fine_mode,
  input  logic [4:0]       tx_level,
  input  logic [4:0]       rx_level,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             tx_write,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic             ls_error,
  input  logic             ls_read,
  input  logic             modem_change,
  input  logic             modem_read,
  input  logic             auto_flow,
  output logic [3:0]       irq_id,
  output logic             irq_pending
);
  logic   tx_trig, rx_trig, tx_trig_q, tmo;
  cause_t pend, masked;
  logic [3:0] next_id;

  uart_irq_trig #(.DEPTH(DEPTH), .FINE_EN(FINE_EN)) u_trig (
    .fine_mode(fine_mode), .tx_level(tx_level), .rx_level(rx_level),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_trig(tx_trig), .rx_trig(rx_trig)
  );

  uart_irq_rxto #(.DEPTH(DEPTH), .TIMEOUT_CHARS(TIMEOUT_CHARS)) u_rxto (
    .clk(clk), .rst(rst), .rx_count(rx_count), .rx_push(rx_push),
    .rx_pop(rx_pop), .char_tick(char_tick), .timeout(tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      tx_trig_q <= 1'b0;
    end else begin
      tx_trig_q <= tx_trig;
      pend.rxd  <= rx_trig;
      pend.tmo  <= tmo;
      if (ls_error)     pend.line <= 1'b1;
      else if (ls_read) pend.line <= 1'b0;
      if (tx_write)                    pend.txs <= 1'b0;
      else if (tx_trig && !tx_trig_q)  pend.txs <= 1'b1;
      if (modem_change && !auto_flow)  pend.mdm <= 1'b1;
      else if (modem_read)             pend.mdm <= 1'b0;
    end
  end

  always_comb begin
    masked     = pend;
    masked.mdm = pend.mdm && !auto_flow;
  end

  uart_irq_encode u_enc (.cause(masked), .id(next_id));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_id      <= ID_NONE;
      irq_pending <= 1'b0;
    end else begin
      irq_id      <= next_id;
      irq_pending <= !next_id[0];
    end
  end

  a_r10_id_legal: assert property (@(posedge clk) disable iff (rst)
    id_legal(irq_id));
  a_r10_pending_matches_id: assert property (@(posedge clk) disable iff (rst)
    irq_pending == !irq_id[0]);
  a_r6_write_clears_tx: assert property (@(posedge clk) disable iff (rst)
    tx_write |=> !pend.txs);
  a_r7_error_sets_line: assert property (@(posedge clk) disable iff (rst)
    ls_error |=> pend.line);
  a_r9_line_wins: assert property (@(posedge clk) disable iff (rst)
    pend.line |=> irq_id == ID_LINE);
  a_r8_modem_hidden: assert property (@(posedge clk) disable iff (rst)
    auto_flow |=> irq_id != ID_MODEM);
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NV    = 13;
  // vector: {fine, rx_level[4:0], rx_count[5:0], expected id[3:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 5'd0,  6'd0,  4'h1}, {1'b0, 5'd0,  6'd1,  4'h4},
    {1'b0, 5'd1,  6'd3,  4'h1}, {1'b0, 5'd1,  6'd4,  4'h4},
    {1'b0, 5'd2,  6'd7,  4'h1}, {1'b0, 5'd2,  6'd8,  4'h4},
    {1'b0, 5'd3,  6'd13, 4'h1}, {1'b0, 5'd3,  6'd14, 4'h4},
    {1'b1, 5'd5,  6'd5,  4'h1}, {1'b1, 5'd5,  6'd6,  4'h4},
    {1'b1, 5'd0,  6'd1,  4'h4}, {1'b1, 5'd15, 6'd15, 4'h1},
    {1'b1, 5'd15, 6'd16, 4'h4}
  };

  logic clk = 0, rst = 1;
  logic fine_mode = 0, tx_write = 0, rx_push = 0, rx_pop = 0, char_tick = 0;
  logic ls_error = 0, ls_read = 0, modem_change = 0, modem_read = 0, auto_flow = 0;
  logic [4:0] tx_level = 0, rx_level = 0;
  logic [CNT_W-1:0] tx_count = CNT_W'(DEPTH), rx_count = 0;
  logic [3:0] irq_id;
  logic irq_pending;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_ident #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .fine_mode(fine_mode), .tx_level(tx_level),
    .rx_level(rx_level), .tx_count(tx_count), .rx_count(rx_count),
    .tx_write(tx_write), .rx_push(rx_push), .rx_pop(rx_pop),
    .char_tick(char_tick), .ls_error(ls_error), .ls_read(ls_read),
    .modem_change(modem_change), .modem_read(modem_read),
    .auto_flow(auto_flow), .irq_id(irq_id), .irq_pending(irq_pending)
  );

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (irq_id !== exp || irq_pending !== !exp[0]) begin
      fails++;
      $display("FAIL %s: irq_id=%h pending=%b expected id=%h", req, irq_id, irq_pending, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) char_tick = 1;
    @(negedge clk) char_tick = 0;
  endtask

  initial begin
    repeat (5000) @(negedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", 4'h1);
    rst = 0;
    settle();
    check("R1 after reset", 4'h1);

    // R3 / R4 receive thresholds from the table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fine_mode = VEC[i][15];
      rx_level  = VEC[i][14:10];
      rx_count  = CNT_W'(VEC[i][9:4]);
      settle();
      check(VEC[i][15] ? "R4 fine rx" : "R3 coarse rx", VEC[i][3:0]);
    end

    // R2 coarse TX below half, R6 clear on write
    @(negedge clk); rx_count = 0; fine_mode = 0; tx_level = 5'd2; tx_count = 10;
    settle(); check("R2 tx 10 not below half", 4'h1);
    tx_count = 8; settle(); check("R2 tx 8 not below half", 4'h1);
    tx_count = 7; settle(); check("R2 tx 7 below half", 4'h2);
    tx_write = 1; @(negedge clk) tx_write = 0;
    settle(); check("R6 write clears tx", 4'h1);

    // R4 fine TX
    tx_count = CNT_W'(DEPTH); fine_mode = 1; tx_level = 5'd9;
    settle(); check("R4 fine tx full", 4'h1);
    tx_count = 10; settle(); check("R4 fine tx 10 > 9", 4'h1);
    tx_count = 9; settle(); check("R4 fine tx 9 <= 9", 4'h2);
    tx_write = 1; tx_count = CNT_W'(DEPTH); @(negedge clk) tx_write = 0;
    tx_level = 0; settle(); check("R6 tx cleared and full", 4'h1);

    // R5 timeout, R7 line status, R9 priority
    fine_mode = 0; rx_level = 0; rx_count = 2;
    settle(); check("R9 rx data code", 4'h4);
    repeat (3) tick();
    settle(); check("R5 three ticks no timeout", 4'h4);
    tick(); settle(); check("R5 fourth tick timeout", 4'hC);
    ls_error = 1; @(negedge clk) ls_error = 0;
    settle(); check("R7 R9 line status over timeout", 4'h6);
    ls_read = 1; @(negedge clk) ls_read = 0;
    settle(); check("R7 status read clears", 4'hC);
    rx_pop = 1; @(negedge clk) rx_pop = 0;
    settle(); check("R5 pop restarts timeout", 4'h4);
    repeat (2) tick();
    rx_push = 1; @(negedge clk) rx_push = 0;
    repeat (2) tick();
    settle(); check("R5 push restarts timeout", 4'h4);
    ls_error = 1; ls_read = 1; @(negedge clk) begin ls_error = 0; ls_read = 0; end
    settle(); check("R7 error wins over read", 4'h6);
    ls_read = 1; @(negedge clk) ls_read = 0;

    // R5 empty never times out
    rx_count = 0; repeat (5) tick();
    settle(); check("R5 empty no timeout", 4'h1);

    // R8 modem
    modem_change = 1; @(negedge clk) modem_change = 0;
    settle(); check("R8 R9 modem code", 4'h0);
    auto_flow = 1; settle(); check("R8 hidden under auto flow", 4'h1);
    auto_flow = 0; settle(); check("R8 reappears", 4'h0);
    modem_read = 1; @(negedge clk) modem_read = 0;
    settle(); check("R8 read clears", 4'h1);
    auto_flow = 1; modem_change = 1; @(negedge clk) modem_change = 0;
    settle(); auto_flow = 0; settle(); check("R8 not set under auto flow", 4'h1);

    // R10 latency: one edge is not enough, two are
    @(negedge clk) rx_count = 1;
    @(negedge clk) check("R10 one edge later", 4'h1);
    @(negedge clk) check("R10 two edges later", 4'h4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule